// File: doc/BRIEF.md
# Noncacheable Instruction Line Buffer

This block holds one line of instruction words fetched from a region marked noncacheable, so that repeated fetches from the same line are served locally instead of going to the external bus. When an eligible instruction fetch misses, the block asks for the bus and records the line address. It then takes the four words of the burst that follows, in order, and marks the line valid. Later noncacheable reads that fall in that line return the held word one cycle after the request and raise no bus request.

The held line is a deliberate weak spot for coherency. A write to the same address goes to the bus and leaves the held copy alone, so a later read returns the old value. The line is dropped only by an invalidate-all pulse, by the start of another cache-inhibited burst on the bus, by a cacheable miss that begins a line fill, or by being replaced with a new capture. A keep-enable input gates new captures only.

Top module: `nc_ifetch_buffer`

## Requirements
- R1: In the cycle after reset is released, `hit` and `bus_req` are 0 and no line is held, so the first noncacheable fetch misses.
- R2: A noncacheable access (`req_inhibit`=1) that does not hit gives `bus_req`=1, `hit`=0 and `hit_data`=0 in the cycle after the request.
- R3: An instruction read (`req_ifetch`=1, `req_write`=0) with transfer type `req_xtype`=0 that misses while `keep_en`=1 starts a capture. The next four `fill_valid` beats store words 0,1,2,3 of the line. After the fourth beat, a noncacheable read whose address bits above bit 3 match gives `hit`=1, `bus_req`=0 and the word picked by address bits [3:2] on `hit_data`, one cycle after the request.
- R4: With `keep_en`=0, a missing instruction fetch is not captured. Beats that follow it are ignored, and the line already held stays valid.
- R5: A noncacheable data read (`req_ifetch`=0) or an instruction read with `req_xtype` other than 0 is not captured and does not disturb the held line.
- R6: Clearing `keep_en` does not invalidate a line already held.
- R7: An `inval_all` pulse drops the held line. A read of that line in a later cycle misses.
- R8: An `inh_burst` pulse, which marks another cache-inhibited burst starting on the bus, drops the held line.
- R9: A `miss_fill` pulse, which marks a miss that starts a fill, drops the held line.
- R10: A noncacheable write gives `bus_req`=1 and `hit`=0 and leaves the held line unchanged, even at the held address. A later read of that address returns the old word.
- R11: An access with `req_inhibit`=0 is cacheable and is not handled here: `hit` and `bus_req` stay 0 in the cycle after it.
- R12: A capture for a new line replaces the old one, which then misses. A read at the same offset in a different line misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | 1 = instruction fetch |
| req_inhibit | input | 1 | 1 = noncacheable region |
| req_xtype | input | 2 | Transfer type, 0 = normal |
| keep_en | input | 1 | Allows new captures of noncacheable fetches |
| fill_valid | input | 1 | Burst beat present |
| fill_data | input | 32 | Burst beat word |
| inval_all | input | 1 | Invalidate-all pulse |
| inh_burst | input | 1 | Another cache-inhibited burst begins |
| miss_fill | input | 1 | A miss starts a line fill |
| hit | output | 1 | Previous cycle's access was served from the line |
| hit_data | output | 32 | Served word, 0 when `hit` is 0 |
| bus_req | output | 1 | Previous cycle's noncacheable access needs the bus |

## Verification
All three outputs are registered. The response to a request is therefore due just after the rising edge that samples the request, and the bench reads it 2 ns after that edge. The last fill beat sets the line valid at its own edge, so a request in the next cycle can already hit. Drop pulses act at their edge, so a request one cycle later sees the line gone. The bench queues an expected response for every request it drives and pops one only in the cycle after a request edge, which keeps each comparison aligned to the cycle it belongs to.

// File: rtl/ncfb_pkg.sv
package ncfb_pkg;

    localparam int unsigned NCFB_ADDR_W     = 32;
    localparam int unsigned NCFB_DATA_W     = 32;
    localparam int unsigned NCFB_LINE_WORDS = 4;
    localparam int unsigned NCFB_XT_W       = 2;

    // Access descriptor carried alongside the address
    typedef struct packed {
        logic                 write;
        logic                 ifetch;
        logic                 inhibit;
        logic [NCFB_XT_W-1:0] xtype;
    } ncfb_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } ncfb_state_t;

    typedef struct packed {
        logic hit;
        logic bus;
    } ncfb_flags_t;

    function automatic logic nc_read(input ncfb_kind_t k);
        return k.inhibit && !k.write;
    endfunction

    // Only normal-type noncacheable instruction reads may be retained
    function automatic logic keepable(input ncfb_kind_t k);
        return nc_read(k) && k.ifetch && (k.xtype == '0);
    endfunction

endpackage

// File: rtl/ncfb_lookup.sv
module ncfb_lookup
    import ncfb_pkg::*;
#(
    parameter int unsigned ADDR_W = NCFB_ADDR_W,
    parameter int unsigned OFS_W  = 4,
    parameter int unsigned SEL_W  = 2
) (
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  ncfb_kind_t              kind,
    input  logic                    keep_en,
    input  logic                    held_valid,
    input  logic [ADDR_W-OFS_W-1:0] held_tag,
    input  logic                    filling,
    output logic [ADDR_W-OFS_W-1:0] req_tag,
    output logic [SEL_W-1:0]        req_sel,
    output ncfb_flags_t             flags,
    output logic                    capture
);

    logic tag_eq;
    logic nc_acc;
    logic is_hit;
    logic unused_byte_bits;

    assign req_tag          = req_addr[ADDR_W-1:OFS_W];
    assign req_sel          = req_addr[OFS_W-1 -: SEL_W];
    assign unused_byte_bits = ^req_addr[OFS_W-SEL_W-1:0];

    always_comb begin
        tag_eq    = (req_tag == held_tag);
        nc_acc    = req_valid && kind.inhibit;
        is_hit    = nc_acc && nc_read(kind) && held_valid && tag_eq;
        flags.hit = is_hit;
        flags.bus = nc_acc && !is_hit;
        capture   = nc_acc && !is_hit && keepable(kind) && keep_en && !filling;
    end

endmodule

// File: rtl/ncfb_line_store.sv
module ncfb_line_store
    import ncfb_pkg::*;
#(
    parameter int unsigned DATA_W = NCFB_DATA_W,
    parameter int unsigned WORDS  = NCFB_LINE_WORDS,
    parameter int unsigned TAG_W  = 28,
    parameter int unsigned SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic              drop,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic              held_valid,
    output logic [TAG_W-1:0]  held_tag,
    output logic              filling,
    output logic [DATA_W-1:0] rd_data
);

    ncfb_state_t                  state;
    logic [SEL_W-1:0]             beat_idx;
    logic [WORDS-1:0][DATA_W-1:0] slot_bus;
    logic                         take_beat;
    logic                         last_beat;

    assign take_beat = (state == ST_FILL) && beat_valid && !drop;
    assign last_beat = take_beat && (beat_idx == SEL_W'(WORDS - 1));
    assign filling   = (state == ST_FILL);

    // Line state: drop beats capture, capture beats beat acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            held_valid <= 1'b0;
            held_tag   <= '0;
            beat_idx   <= '0;
        end else if (drop) begin
            state      <= ST_IDLE;
            held_valid <= 1'b0;
            beat_idx   <= '0;
        end else if (capture) begin
            state      <= ST_FILL;
            held_valid <= 1'b0;
            held_tag   <= cap_tag;
            beat_idx   <= '0;
        end else if (take_beat) begin
            beat_idx <= beat_idx + 1'b1;
            if (last_beat) begin
                state      <= ST_IDLE;
                held_valid <= 1'b1;
            end
        end
    end

    // One register per word of the line
    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (take_beat && (beat_idx == SEL_W'(w))) begin
                slot_q <= beat_data;
            end
        end
        assign slot_bus[w] = slot_q;
    end

    assign rd_data = slot_bus[rd_sel];

endmodule

// File: rtl/ncfb_resp.sv
module ncfb_resp
    import ncfb_pkg::*;
#(
    parameter int unsigned DATA_W = NCFB_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ncfb_flags_t       flags,
    input  logic [DATA_W-1:0] rd_data,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              bus_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit      <= 1'b0;
            bus_req  <= 1'b0;
            hit_data <= '0;
        end else begin
            hit      <= flags.hit;
            bus_req  <= flags.bus;
            hit_data <= flags.hit ? rd_data : '0;
        end
    end

endmodule

// File: rtl/nc_ifetch_buffer.sv
module nc_ifetch_buffer
    import ncfb_pkg::*;
#(
    parameter int unsigned ADDR_W = NCFB_ADDR_W,
    parameter int unsigned DATA_W = NCFB_DATA_W,
    parameter int unsigned WORDS  = NCFB_LINE_WORDS,
    parameter int unsigned XT_W   = NCFB_XT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_ifetch,
    input  logic              req_inhibit,
    input  logic [XT_W-1:0]   req_xtype,
    input  logic              keep_en,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inval_all,
    input  logic              inh_burst,
    input  logic              miss_fill,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              bus_req
);

    localparam int unsigned SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int unsigned OFS_W = $clog2(WORDS * (DATA_W / 8));
    localparam int unsigned TAG_W = ADDR_W - OFS_W;

    ncfb_kind_t        kind;
    ncfb_flags_t       flags;
    logic              capture;
    logic              drop;
    logic              held_valid;
    logic              filling;
    logic [TAG_W-1:0]  held_tag;
    logic [TAG_W-1:0]  req_tag;
    logic [SEL_W-1:0]  req_sel;
    logic [DATA_W-1:0] rd_data;

    assign kind.write   = req_write;
    assign kind.ifetch  = req_ifetch;
    assign kind.inhibit = req_inhibit;
    assign kind.xtype   = req_xtype;
    assign drop         = inval_all || inh_burst || miss_fill;

    ncfb_lookup #(
        .ADDR_W(ADDR_W),
        .OFS_W (OFS_W),
        .SEL_W (SEL_W)
    ) u_lookup (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .kind      (kind),
        .keep_en   (keep_en),
        .held_valid(held_valid),
        .held_tag  (held_tag),
        .filling   (filling),
        .req_tag   (req_tag),
        .req_sel   (req_sel),
        .flags     (flags),
        .capture   (capture)
    );

    ncfb_line_store #(
        .DATA_W(DATA_W),
        .WORDS (WORDS),
        .TAG_W (TAG_W),
        .SEL_W (SEL_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .cap_tag   (req_tag),
        .drop      (drop),
        .beat_valid(fill_valid),
        .beat_data (fill_data),
        .rd_sel    (req_sel),
        .held_valid(held_valid),
        .held_tag  (held_tag),
        .filling   (filling),
        .rd_data   (rd_data)
    );

    ncfb_resp #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .rd_data (rd_data),
        .hit     (hit),
        .hit_data(hit_data),
        .bus_req (bus_req)
    );

endmodule

// File: rtl/nc_ifetch_buffer_chk.sv
module nc_ifetch_buffer_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_write,
    input logic req_inhibit,
    input logic inval_all,
    input logic inh_burst,
    input logic miss_fill,
    input logic hit,
    input logic bus_req
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!hit && !bus_req));

    a_r2_nc_access_answered: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_inhibit) |=> (hit || bus_req));

    a_r3_hit_from_nc_read: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(req_valid && req_inhibit && !req_write));

    // R8 and R9 share this window with R7
    a_r7_drop_blocks_hit: assert property (@(posedge clk) disable iff (rst)
        (inval_all || inh_burst || miss_fill) |=> ##1 !hit);

    a_r10_write_to_bus: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_inhibit) |=> (bus_req && !hit));

    a_r11_cacheable_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_inhibit) |=> (!hit && !bus_req));

endmodule

bind nc_ifetch_buffer nc_ifetch_buffer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_inhibit(req_inhibit),
    .inval_all  (inval_all),
    .inh_burst  (inh_burst),
    .miss_fill  (miss_fill),
    .hit        (hit),
    .bus_req    (bus_req)
);

// File: tb/nc_ifetch_buffer_test.sv
module nc_ifetch_buffer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_ifetch = 1'b0;
    logic        req_inhibit = 1'b0;
    logic [1:0]  req_xtype = '0;
    logic        keep_en = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        inval_all = 1'b0;
    logic        inh_burst = 1'b0;
    logic        miss_fill = 1'b0;
    logic        hit;
    logic [31:0] hit_data;
    logic        bus_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic        hit;
        logic        bus;
        logic [31:0] data;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    nc_ifetch_buffer uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_ifetch (req_ifetch),
        .req_inhibit(req_inhibit),
        .req_xtype  (req_xtype),
        .keep_en    (keep_en),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .inval_all  (inval_all),
        .inh_burst  (inh_burst),
        .miss_fill  (miss_fill),
        .hit        (hit),
        .hit_data   (hit_data),
        .bus_req    (bus_req)
    );

    // Driver: one-cycle request, expected response queued alongside
    task automatic access(input logic [31:0] a, input logic wr, input logic ifc,
                          input logic inh, input logic [1:0] xt,
                          input logic e_hit, input logic e_bus, input logic [31:0] e_data,
                          input string rq);
        exp_t e;
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_write   = wr;
        req_ifetch  = ifc;
        req_inhibit = inh;
        req_xtype   = xt;
        e.hit  = e_hit;
        e.bus  = e_bus;
        e.data = e_data;
        exp_q.push_back(e);
        tag_q.push_back(rq);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a, input logic e_hit, input logic e_bus,
                         input logic [31:0] e_data, input string rq);
        access(a, 1'b0, 1'b1, 1'b1, 2'd0, e_hit, e_bus, e_data, rq);
    endtask

    task automatic fill_line(input logic [31:0] base);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fill_valid = 1'b1;
            fill_data  = base + 32'(i);
        end
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        inval_all = (which == 0);
        inh_burst = (which == 1);
        miss_fill = (which == 2);
        @(negedge clk);
        inval_all = 1'b0;
        inh_burst = 1'b0;
        miss_fill = 1'b0;
    endtask

    // Monitor: response is due just after the edge that samples a request
    always @(posedge clk) begin
        if (!rst && req_valid) begin
            exp_t  e;
            string rq;
            #2;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: response with no expectation (actual hit=%0b bus=%0b, expected none)",
                         hit, bus_req);
            end else begin
                e  = exp_q.pop_front();
                rq = tag_q.pop_front();
                if (hit !== e.hit || bus_req !== e.bus || hit_data !== e.data) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0b bus=%0b data=%h, expected hit=%0b bus=%0b data=%h",
                             rq, hit, bus_req, hit_data, e.hit, e.bus, e.data);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (hit !== 1'b0 || bus_req !== 1'b0 || hit_data !== 32'h0) begin
            fails++;
            $display("FAIL R1: actual hit=%0b bus=%0b data=%h, expected 0 0 00000000",
                     hit, bus_req, hit_data);
        end
        keep_en = 1'b1;

        // R1/R2: nothing held, miss requests the bus and starts a capture
        fetch(32'h1000, 1'b0, 1'b1, 32'h0, "R2");
        fill_line(32'hC0DE_0000);
        fetch(32'h1008, 1'b1, 1'b0, 32'hC0DE_0002, "R3");
        fetch(32'h100C, 1'b1, 1'b0, 32'hC0DE_0003, "R3");
        fetch(32'h1000, 1'b1, 1'b0, 32'hC0DE_0000, "R3");

        // R5: data read and non-normal type leave the line alone
        access(32'h2004, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, "R5");
        fetch(32'h1004, 1'b1, 1'b0, 32'hC0DE_0001, "R5");
        access(32'h3000, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 32'h0, "R5");
        fetch(32'h1004, 1'b1, 1'b0, 32'hC0DE_0001, "R5");

        // R10: write to held address, later read is stale
        access(32'h1008, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, "R10");
        fetch(32'h1008, 1'b1, 1'b0, 32'hC0DE_0002, "R10");

        // R11: cacheable access is not handled here
        access(32'h1000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, "R11");

        // R6/R4: enable cleared
        keep_en = 1'b0;
        fetch(32'h1000, 1'b1, 1'b0, 32'hC0DE_0000, "R6");
        fetch(32'h4000, 1'b0, 1'b1, 32'h0, "R4");
        fill_line(32'hDEAD_0000);
        fetch(32'h1000, 1'b1, 1'b0, 32'hC0DE_0000, "R4");
        fetch(32'h4000, 1'b0, 1'b1, 32'h0, "R4");
        keep_en = 1'b1;

        // R8: another inhibited burst displaces the line
        pulse(1);
        fetch(32'h1004, 1'b0, 1'b1, 32'h0, "R8");
        fill_line(32'hBEEF_0000);
        fetch(32'h1004, 1'b1, 1'b0, 32'hBEEF_0001, "R3");

        // R9: miss that starts a fill displaces the line
        pulse(2);
        access(32'h1004, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, "R9");
        fetch(32'h1000, 1'b0, 1'b1, 32'h0, "R9");
        fill_line(32'hCAFE_0000);
        fetch(32'h100C, 1'b1, 1'b0, 32'hCAFE_0003, "R3");

        // R7: invalidate-all
        pulse(0);
        access(32'h100C, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, "R7");

        // R12: replacement and tag compare
        fetch(32'h1000, 1'b0, 1'b1, 32'h0, "R12");
        fill_line(32'hD00D_0000);
        fetch(32'h5008, 1'b0, 1'b1, 32'h0, "R12");
        fill_line(32'hE000_0000);
        access(32'h1000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, "R12");
        fetch(32'h5008, 1'b1, 1'b0, 32'hE000_0002, "R12");
        access(32'h6008, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, "R12");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: %0d responses missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule